// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block sits inside one processing partition. It picks at most one warp per clock to take the shared issue slot. Each resident warp stands for 32 threads that run a single instruction stream. Each warp carries a per-thread active mask, which records which lanes take part when it issues. The chosen warp ID and its mask go out together, so fetch and decode are spent once per warp and not once per thread. A lane whose bit is clear sits idle while its warp still uses the slot.

When the instruction being issued is a memory access, the issuing warp is parked. It stays parked until a memory-response pulse carrying its ID comes back. In the meantime the scheduler rotates through the other warps that can issue, which hides the memory latency. Warps enter the pool through an allocate port and leave it through a free port. A mask-write port updates a warp's mask when its threads diverge or reconverge. The block reports how many warps are resident, which is the numerator of the occupancy ratio. It also keeps a saturating count of cycles in which nothing could issue.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is resident, `issue_valid` is 0, `occupancy` is 0 and `stall_count` is 0.
- R2: An allocate of warp ID k with mask M makes warp k resident and ready with mask M from the next cycle. `occupancy` always equals the number of resident warps.
- R3: While `issue_valid` is 1, `issue_id` names a resident, non-waiting warp and `issue_mask` is that warp's current 32-bit mask. Bit i is lane i.
- R4: The issued warp is the first ready warp in ascending ID order, wrapping, starting one after the warp issued most recently. After reset the search starts at warp 0.
- R5: When a warp issues while `issue_is_mem` is 1, it becomes waiting and is not issued again until released.
- R6: A `mem_resp_valid` pulse with ID k clears warp k's waiting state, so it may issue from the next cycle.
- R7: If warp k issues in the same cycle as a response for k arrives, warp k ends waiting exactly when `issue_is_mem` is 1 in that cycle.
- R8: In a cycle with no ready warp, `issue_valid` is 0 and `stall_count` rises by one in the next cycle, saturating at its maximum. In a cycle with a ready warp it is unchanged.
- R9: A free of warp k removes it from the pool, clearing its waiting state and mask, and `occupancy` drops by one.
- R10: A mask write to resident warp k replaces its mask from the next cycle. A warp whose mask is all zero still takes the issue slot when chosen.
- R11: A response for a warp that is neither waiting nor issuing in that cycle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a warp this cycle |
| alloc_id | input | IDW | Warp ID to allocate |
| alloc_mask | input | LANES | Initial active-thread mask |
| free_valid | input | 1 | Free a warp this cycle |
| free_id | input | IDW | Warp ID to free |
| mask_wr_valid | input | 1 | Replace a resident warp's mask |
| mask_wr_id | input | IDW | Warp whose mask is replaced |
| mask_wr_value | input | LANES | New active-thread mask |
| mem_resp_valid | input | 1 | Memory-response pulse |
| mem_resp_id | input | IDW | Warp the response belongs to |
| issue_is_mem | input | 1 | The instruction issued this cycle is a memory operation |
| issue_valid | output | 1 | A warp takes the issue slot this cycle |
| issue_id | output | IDW | Issuing warp ID |
| issue_mask | output | LANES | Active mask of the issuing warp |
| occupancy | output | OCC_W | Number of resident warps |
| stall_count | output | CNT_W | Saturating count of cycles with no ready warp |

## Verification
The checks assume the neighbours follow the allocation protocol. An allocate names only a warp that is not resident, and a free or mask write names only a resident warp. Allocate and free never target the same warp in the same cycle. The stimulus, both directed and random, chooses its IDs from the bench's own record of which warps are resident, so it keeps to these rules. Memory responses, by contrast, may name any warp at any time: the bench sends them to idle, ready and just-issued warps on purpose, to exercise R7 and R11.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  localparam int MAX_WARPS = 64;

  // number of set bits in a warp vector
  function automatic int count_ones(input logic [MAX_WARPS-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < MAX_WARPS; i++) c += int'(v[i]);
    return c;
  endfunction

  // first ready warp after 'last', wrapping within n warps; -1 if none
  function automatic int rr_next(input logic [MAX_WARPS-1:0] rdy, input int n, input int last);
    int found;
    int idx;
    found = -1;
    for (int k = 1; k <= MAX_WARPS; k++) begin
      idx = last + k;
      if (idx >= n) idx = idx - n;
      if (idx >= n) idx = idx - n;
      if (found < 0 && k <= n && rdy[idx]) found = idx;
    end
    return found;
  endfunction

endpackage

// File: rtl/warp_slot.sv
module warp_slot #(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_hit,
  input  logic [LANES-1:0] alloc_mask,
  input  logic             free_hit,
  input  logic             mask_hit,
  input  logic [LANES-1:0] mask_value,
  input  logic             issue_hit,
  input  logic             issue_mem,
  input  logic             resp_hit,
  output logic             resident,
  output logic             waiting,
  output logic [LANES-1:0] mask
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resident <= 1'b0;
      waiting  <= 1'b0;
      mask     <= '0;
    end else if (free_hit) begin
      resident <= 1'b0;
      waiting  <= 1'b0;
      mask     <= '0;
    end else if (alloc_hit) begin
      resident <= 1'b1;
      waiting  <= 1'b0;
      mask     <= alloc_mask;
    end else begin
      if (mask_hit) mask <= mask_value;
      if (issue_hit && issue_mem) waiting <= 1'b1;
      else if (resp_hit) waiting <= 1'b0;
    end
  end

  AST_WAIT_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> resident); // R9
  AST_MEM_BEATS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_hit && issue_mem && !free_hit && !alloc_hit) |=> waiting); // R7
  AST_RESP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_hit && !issue_hit && !free_hit && !alloc_hit) |=> !waiting); // R6

endmodule

// File: rtl/rr_picker.sv
module rr_picker
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int IDW = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] ready,
  output logic                 pick_valid,
  output logic [IDW-1:0]       pick_id
);

  logic [IDW-1:0]       last_q;
  logic [MAX_WARPS-1:0] rdy_ext;
  int                   found;

  always_comb begin
    rdy_ext = '0;
    rdy_ext[NUM_WARPS-1:0] = ready;
    found = rr_next(rdy_ext, NUM_WARPS, int'(last_q));
    pick_valid = (found >= 0);
    pick_id = pick_valid ? IDW'(found) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IDW'(NUM_WARPS - 1);
    else if (pick_valid) last_q <= pick_id;
  end

  AST_PICK_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> ready[pick_id]); // R3
  AST_READY_GETS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready) |-> pick_valid); // R8

endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (stall && count != {CNT_W{1'b1}}) count <= count + 1'b1;
  end

  AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && count != {CNT_W{1'b1}}) |=> count == $past(count) + 1'b1); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> $stable(count)); // R8

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int LANES = 32,
  parameter int CNT_W = 16,
  localparam int IDW = $clog2(NUM_WARPS),
  localparam int OCC_W = $clog2(NUM_WARPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [IDW-1:0]   alloc_id,
  input  logic [LANES-1:0] alloc_mask,
  input  logic             free_valid,
  input  logic [IDW-1:0]   free_id,
  input  logic             mask_wr_valid,
  input  logic [IDW-1:0]   mask_wr_id,
  input  logic [LANES-1:0] mask_wr_value,
  input  logic             mem_resp_valid,
  input  logic [IDW-1:0]   mem_resp_id,
  input  logic             issue_is_mem,
  output logic             issue_valid,
  output logic [IDW-1:0]   issue_id,
  output logic [LANES-1:0] issue_mask,
  output logic [OCC_W-1:0] occupancy,
  output logic [CNT_W-1:0] stall_count
);

  logic [NUM_WARPS-1:0] resident;
  logic [NUM_WARPS-1:0] waiting;
  logic [NUM_WARPS-1:0] ready;
  logic [LANES-1:0]     slot_mask [NUM_WARPS];
  logic                 no_ready_stall;
  logic [MAX_WARPS-1:0] res_ext;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic alloc_hit, free_hit, mask_hit, issue_hit, resp_hit;
    assign alloc_hit = alloc_valid    && (alloc_id    == IDW'(w));
    assign free_hit  = free_valid     && (free_id     == IDW'(w));
    assign mask_hit  = mask_wr_valid  && (mask_wr_id  == IDW'(w));
    assign issue_hit = issue_valid    && (issue_id    == IDW'(w));
    assign resp_hit  = mem_resp_valid && (mem_resp_id == IDW'(w));

    warp_slot #(.LANES(LANES)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_hit  (alloc_hit),
      .alloc_mask (alloc_mask),
      .free_hit   (free_hit),
      .mask_hit   (mask_hit),
      .mask_value (mask_wr_value),
      .issue_hit  (issue_hit),
      .issue_mem  (issue_is_mem),
      .resp_hit   (resp_hit),
      .resident   (resident[w]),
      .waiting    (waiting[w]),
      .mask       (slot_mask[w])
    );
  end

  assign ready = resident & ~waiting;

  rr_picker #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .pick_valid (issue_valid),
    .pick_id    (issue_id)
  );

  assign issue_mask     = issue_valid ? slot_mask[issue_id] : '0;
  assign no_ready_stall = !issue_valid;

  stall_counter #(.CNT_W(CNT_W)) u_stall (
    .clk   (clk),
    .rst_n (rst_n),
    .stall (no_ready_stall),
    .count (stall_count)
  );

  always_comb begin
    res_ext = '0;
    res_ext[NUM_WARPS-1:0] = resident;
  end
  assign occupancy = OCC_W'(count_ones(res_ext));

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(NUM_WARPS)); // R2
  AST_ISSUED_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (resident[issue_id] && !waiting[issue_id])); // R3
  AST_MEM_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_is_mem && !(free_valid && free_id == issue_id))
    |=> waiting[$past(issue_id)]); // R5
  AST_ALLOC_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !(free_valid && free_id == alloc_id))
    |=> ready[$past(alloc_id)]); // R2

endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;

  localparam int NW = 8;
  localparam int LN = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alloc_valid, free_valid, mask_wr_valid, mem_resp_valid, issue_is_mem;
  logic [2:0]    alloc_id, free_id, mask_wr_id, mem_resp_id;
  logic [LN-1:0] alloc_mask, mask_wr_value;
  logic          issue_valid;
  logic [2:0]    issue_id;
  logic [LN-1:0] issue_mask;
  logic [3:0]    occupancy;
  logic [CW-1:0] stall_count;

  always #5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .LANES(LN), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_id(alloc_id), .alloc_mask(alloc_mask),
    .free_valid(free_valid), .free_id(free_id),
    .mask_wr_valid(mask_wr_valid), .mask_wr_id(mask_wr_id), .mask_wr_value(mask_wr_value),
    .mem_resp_valid(mem_resp_valid), .mem_resp_id(mem_resp_id),
    .issue_is_mem(issue_is_mem),
    .issue_valid(issue_valid), .issue_id(issue_id), .issue_mask(issue_mask),
    .occupancy(occupancy), .stall_count(stall_count)
  );

  // behavioural reference state
  bit          m_res [NW];
  bit          m_wait [NW];
  bit [LN-1:0] m_mask [NW];
  int          m_last;
  int          m_stall;
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 0;

  function automatic int model_pick();
    for (int k = 1; k <= NW; k++) begin
      int w = (m_last + k) % NW;
      if (m_res[w] && !m_wait[w]) return w;
    end
    return -1;
  endfunction

  function automatic int model_occ();
    int c = 0;
    for (int w = 0; w < NW; w++) c += m_res[w];
    return c;
  endfunction

  function automatic int free_slot();
    for (int w = 0; w < NW; w++) if (!m_res[w]) return w;
    return -1;
  endfunction

  task automatic compare(input string tag);
    int e = model_pick();
    bit ev = (e >= 0);
    bit [LN-1:0] em = ev ? m_mask[e] : '0;
    bit bad;
    bad = (issue_valid !== ev) || (ev && issue_id !== 3'(e)) || (issue_mask !== em)
          || (occupancy !== 4'(model_occ())) || (stall_count !== CW'(m_stall));
    compared++;
    if (bad) begin
      mismatched++;
      $display("FAIL %s: got v=%0d id=%0d mask=%h occ=%0d stall=%0d expected v=%0d id=%0d mask=%h occ=%0d stall=%0d",
               tag, issue_valid, issue_id, issue_mask, occupancy, stall_count,
               ev, e, em, model_occ(), m_stall);
    end
  endtask

  // one cycle: compare at negedge, drive, advance the model, cross the edge
  task automatic step(input string tag,
                      input bit av, input int aid, input bit [LN-1:0] am,
                      input bit fv, input int fid,
                      input bit mv, input int mid, input bit [LN-1:0] mm,
                      input bit rv, input int rid, input bit im);
    int e;
    compare(tag);
    alloc_valid = av;   alloc_id = 3'(aid);   alloc_mask = am;
    free_valid = fv;    free_id = 3'(fid);
    mask_wr_valid = mv; mask_wr_id = 3'(mid); mask_wr_value = mm;
    mem_resp_valid = rv; mem_resp_id = 3'(rid);
    issue_is_mem = im;
    e = model_pick();
    if (e >= 0) m_last = e;
    else if (m_stall < 65535) m_stall++;
    for (int w = 0; w < NW; w++) begin
      if (fv && fid == w) begin
        m_res[w] = 0; m_wait[w] = 0; m_mask[w] = '0;
      end else if (av && aid == w) begin
        m_res[w] = 1; m_wait[w] = 0; m_mask[w] = am;
      end else begin
        if (mv && mid == w) m_mask[w] = mm;
        if (e == w && im) m_wait[w] = 1;
        else if (rv && rid == w) m_wait[w] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input bit im);
    step(tag, 0, 0, '0, 0, 0, 0, 0, '0, 0, 0, im);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int p;
    rst_n = 0;
    alloc_valid = 0; free_valid = 0; mask_wr_valid = 0; mem_resp_valid = 0; issue_is_mem = 0;
    alloc_id = 0; free_id = 0; mask_wr_id = 0; mem_resp_id = 0; alloc_mask = '0; mask_wr_value = '0;
    for (int w = 0; w < NW; w++) begin m_res[w] = 0; m_wait[w] = 0; m_mask[w] = '0; end
    m_last = NW - 1; m_stall = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare("R1 reset state");

    // R2: allocate three warps with distinct masks
    step("R2 alloc", 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, '0, 0, 0, 0);
    step("R2 alloc", 1, 1, 32'h5555_5555, 0, 0, 0, 0, '0, 0, 0, 0);
    step("R2 alloc", 1, 2, 32'h0000_00FF, 0, 0, 0, 0, '0, 0, 0, 0);
    // R4: round robin rotation over 0,1,2
    for (int i = 0; i < 6; i++) idle("R4 rotation", 0);
    // R5: park every warp on memory, then R8 stall cycles
    for (int i = 0; i < 3; i++) idle("R5 mem park", 1);
    for (int i = 0; i < 3; i++) idle("R8 stall", 0);
    // R6: release warp 1
    step("R6 release", 0, 0, '0, 0, 0, 0, 0, '0, 1, 1, 0);
    idle("R6 reissue", 0);
    // R7: response and issue of the same warp in one cycle
    p = model_pick();
    step("R7 resp+alu", 0, 0, '0, 0, 0, 0, 0, '0, 1, p, 0);
    p = model_pick();
    step("R7 resp+mem", 0, 0, '0, 0, 0, 0, 0, '0, 1, p, 1);
    idle("R7 after", 0);
    // R11: stray response to a warp that is not resident / not waiting
    step("R11 stray", 0, 0, '0, 0, 0, 0, 0, '0, 1, 6, 0);
    step("R6 release", 0, 0, '0, 0, 0, 0, 0, '0, 1, 0, 0);
    step("R6 release", 0, 0, '0, 0, 0, 0, 0, '0, 1, 2, 0);
    step("R6 release", 0, 0, '0, 0, 0, 0, 0, '0, 1, 1, 0);
    step("R11 stray ready", 0, 0, '0, 0, 0, 0, 0, '0, 1, (model_pick() + 1) % 3, 0);
    // R10: divergence narrows mask, zero mask still issues
    step("R10 mask", 0, 0, '0, 0, 0, 1, 1, 32'h0000_0003, 0, 0, 0);
    step("R10 mask", 0, 0, '0, 0, 0, 1, 2, 32'h0, 0, 0, 0);
    for (int i = 0; i < 4; i++) idle("R10 issue", 0);
    // R9: free warp 1 and warp 0
    step("R9 free", 0, 0, '0, 1, 1, 0, 0, '0, 0, 0, 0);
    step("R9 free", 0, 0, '0, 1, 0, 0, 0, '0, 0, 0, 0);
    for (int i = 0; i < 3; i++) idle("R9 after", 0);

    // mixed random traffic inside the allocation protocol
    for (int i = 0; i < 600; i++) begin
      bit av, fv, mv, rv, im;
      int aid, fid, mid, rid;
      int tries;
      av = 0; fv = 0; mv = 0; aid = 0; fid = 0; mid = 0;
      aid = free_slot();
      if (aid >= 0 && ($urandom % 4 == 0)) av = 1; else aid = 0;
      if (model_occ() > 0 && ($urandom % 6 == 0)) begin
        tries = 0;
        fid = $urandom % NW;
        while (!(m_res[fid] && !(av && fid == aid)) && tries < 32) begin
          fid = $urandom % NW; tries++;
        end
        fv = m_res[fid] && !(av && fid == aid);
      end
      if (model_occ() > 0 && ($urandom % 5 == 0)) begin
        mid = $urandom % NW;
        mv = m_res[mid];
      end
      rv = ($urandom % 2 == 0);
      rid = $urandom % NW;
      im = ($urandom % 3 == 0);
      step("R3 random", av, aid, $urandom, fv, fid, mv, mid, $urandom, rv, rid, im);
    end
    compare("R3 final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule